// File: doc/BRIEF.md
# Voltage Detector Reaction Controller

This block sits between a bank of configurable low- and high-voltage detectors and the chip's reset, interrupt and fault-collection logic. Each detector's raw trip signal is first filtered by a debouncer, and a confirmed trip raises that detector's pending flag. The flag is then routed to whichever reactions software has enabled for that detector: a reset request (functional or destructive, chosen per detector), an interrupt, or a fault-collection event. A destructive request also pulls an active-low external reset pin low. A further status output tells the reset sequencer to stay in its first phase while any destructive condition is still present at a detector.

At power-up the block waits for a one-time boot configuration word. Each set bit of that word forces the matching detector's reset enable on and locks it against software until the next power-on reset. A small state machine orders this flow. `ST_WAIT_BOOT` is entered on power-on reset and accepts the word (transition *boot_load*). `ST_APPLY` applies the locks for one cycle (transition *apply_done*). `ST_RUN` is where software may access the registers; the block has no transition out of it other than power-on reset.

Top module: `vd_reaction_ctrl`

## Requirements
- R1: A raw trip counts only after it has been high on DEB_CYC consecutive clock edges; a pulse that is high for fewer edges leaves the pending flags unchanged.
- R2: The rising edge of a debounced trip sets that detector's pending flag whatever its enables are; writing 1 to a bit at address 4 (pending) clears it, and writing 0 leaves it.
- R3: Register map, one bit per detector (bit i = detector i): 0 reset enable, 1 reset type (1 = destructive, 0 = functional), 2 interrupt enable, 3 fault enable, 4 pending, 5 lock (read-only); reads at other addresses return 0.
- R4: func_rst_req is 1 exactly when some detector is pending with reset enabled and reset type 0, registered one cycle after the pending state.
- R5: dest_rst_req is 1 exactly when some detector is pending with reset enabled and reset type 1; ext_rst_n is its inverse and is low while it is asserted.
- R6: irq is the OR of pending AND interrupt enable, and fault_evt is the OR of pending AND fault enable; a single trip can raise a reset request, irq and fault_evt together.
- R7: A boot word accepted in ST_WAIT_BOOT copies into the lock register and sets the matching reset-enable bits; locked reset-enable bits read 1 and ignore writes of 0, and unlocked bits are read/write.
- R8: por_n low clears every register, lock and output (ext_rst_n goes to 1); after a new boot with a bit clear, that reset-enable bit is read/write again.
- R9: hold_phase0 is 1 while some detector has its debounced trip high with reset enabled and reset type 1, and it drops when that trip ends even if the flag is still pending.
- R10: Register writes take effect only in ST_RUN, and boot words presented outside ST_WAIT_BOOT are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| boot_cfg_valid | input | 1 | Boot configuration word is valid |
| boot_cfg_word | input | NUM_DET | Reset enables to force and lock |
| trip_raw | input | NUM_DET | Raw detector trip levels |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | NUM_DET | Register write data |
| reg_rdata | output | NUM_DET | Register read data (combinational) |
| func_rst_req | output | 1 | Functional reset request |
| dest_rst_req | output | 1 | Destructive reset request |
| irq | output | 1 | Interrupt line |
| fault_evt | output | 1 | Fault collection event |
| ext_rst_n | output | 1 | Drive for the active-low external reset pin |
| hold_phase0 | output | 1 | Tells the reset sequencer to stay in its first phase |

## Verification
The bench builds the block with NUM_DET = 4 and DEB_CYC = 3. This makes a mix of locked and unlocked detectors possible in one four-bit boot word. It also makes a pulse that is one edge short of confirmation only two cycles long. Both reset types are reached, together with the interrupt and fault routing of one detector and the full sequence of lock, power-on reset and re-boot, all with short directed sequences.

// File: rtl/vdr_pkg.sv
package vdr_pkg;
    typedef enum logic [1:0] {
        ST_WAIT_BOOT = 2'd0,
        ST_APPLY     = 2'd1,
        ST_RUN       = 2'd2
    } vdr_state_e;

    localparam int          ADDR_W     = 3;
    localparam logic [2:0]  ADDR_REE   = 3'd0;
    localparam logic [2:0]  ADDR_RTYPE = 3'd1;
    localparam logic [2:0]  ADDR_IRQEN = 3'd2;
    localparam logic [2:0]  ADDR_FLTEN = 3'd3;
    localparam logic [2:0]  ADDR_PEND  = 3'd4;
    localparam logic [2:0]  ADDR_LOCK  = 3'd5;
endpackage

// File: rtl/vdr_debounce.sv
module vdr_debounce #(
    parameter int DEB_CYC = 16
) (
    input  logic clk,
    input  logic por_n,
    input  logic raw,
    output logic lvl,
    output logic rise
);
    localparam int CNT_W = $clog2(DEB_CYC) + 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEB_CYC - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             lvl_q;
    logic             prev_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cnt_q <= '0;
            lvl_q <= 1'b0;
        end else if (!raw) begin
            cnt_q <= '0;
            lvl_q <= 1'b0;
        end else if (cnt_q == CNT_LAST) begin
            lvl_q <= 1'b1;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) prev_q <= 1'b0;
        else        prev_q <= lvl_q;
    end

    assign lvl  = lvl_q;
    assign rise = lvl_q & ~prev_q;
endmodule

// File: rtl/vdr_regfile.sv
module vdr_regfile
    import vdr_pkg::*;
#(
    parameter int NUM_DET = 12
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [NUM_DET-1:0] wdata,
    input  logic               apply,
    input  logic [NUM_DET-1:0] boot_word,
    input  logic [NUM_DET-1:0] trip_rise,
    output logic [NUM_DET-1:0] rdata,
    output logic [NUM_DET-1:0] ree_o,
    output logic [NUM_DET-1:0] rtype_o,
    output logic [NUM_DET-1:0] ie_o,
    output logic [NUM_DET-1:0] fee_o,
    output logic [NUM_DET-1:0] pend_o,
    output logic [NUM_DET-1:0] lock_o
);
    logic [NUM_DET-1:0] ree_q, rtype_q, ie_q, fee_q, pend_q, lock_q;

    // reset enable and lock: boot load forces, software may only add on top of lock
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            ree_q  <= '0;
            lock_q <= '0;
        end else if (apply) begin
            lock_q <= boot_word;
            ree_q  <= ree_q | boot_word;
        end else if (wr_en && addr == ADDR_REE) begin
            ree_q  <= wdata | lock_q;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            rtype_q <= '0;
            ie_q    <= '0;
            fee_q   <= '0;
        end else if (wr_en) begin
            if (addr == ADDR_RTYPE) rtype_q <= wdata;
            if (addr == ADDR_IRQEN) ie_q    <= wdata;
            if (addr == ADDR_FLTEN) fee_q   <= wdata;
        end
    end

    // pending: per-bit set by trip, write-1-to-clear, set wins
    for (genvar i = 0; i < NUM_DET; i++) begin : g_pend
        always_ff @(posedge clk or negedge por_n) begin
            if (!por_n)
                pend_q[i] <= 1'b0;
            else if (trip_rise[i])
                pend_q[i] <= 1'b1;
            else if (wr_en && addr == ADDR_PEND && wdata[i])
                pend_q[i] <= 1'b0;
        end
    end

    always_comb begin
        unique case (addr)
            ADDR_REE:   rdata = ree_q;
            ADDR_RTYPE: rdata = rtype_q;
            ADDR_IRQEN: rdata = ie_q;
            ADDR_FLTEN: rdata = fee_q;
            ADDR_PEND:  rdata = pend_q;
            ADDR_LOCK:  rdata = lock_q;
            default:    rdata = '0;
        endcase
    end

    assign ree_o   = ree_q;
    assign rtype_o = rtype_q;
    assign ie_o    = ie_q;
    assign fee_o   = fee_q;
    assign pend_o  = pend_q;
    assign lock_o  = lock_q;
endmodule

// File: rtl/vdr_route.sv
module vdr_route #(
    parameter int NUM_DET = 12
) (
    input  logic [NUM_DET-1:0] pend,
    input  logic [NUM_DET-1:0] ree,
    input  logic [NUM_DET-1:0] rtype,
    input  logic [NUM_DET-1:0] ie,
    input  logic [NUM_DET-1:0] fee,
    input  logic [NUM_DET-1:0] lvl,
    output logic               func_any,
    output logic               dest_any,
    output logic               irq_any,
    output logic               flt_any,
    output logic               hold_any
);
    logic [NUM_DET-1:0] func_v, dest_v, irq_v, flt_v, hold_v;

    for (genvar i = 0; i < NUM_DET; i++) begin : g_det
        assign func_v[i] = pend[i] & ree[i] & ~rtype[i];
        assign dest_v[i] = pend[i] & ree[i] &  rtype[i];
        assign irq_v[i]  = pend[i] & ie[i];
        assign flt_v[i]  = pend[i] & fee[i];
        assign hold_v[i] = lvl[i]  & ree[i] &  rtype[i];
    end

    assign func_any = |func_v;
    assign dest_any = |dest_v;
    assign irq_any  = |irq_v;
    assign flt_any  = |flt_v;
    assign hold_any = |hold_v;
endmodule

// File: rtl/vd_reaction_ctrl.sv
module vd_reaction_ctrl
    import vdr_pkg::*;
#(
    parameter int NUM_DET = 12,
    parameter int DEB_CYC = 16
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic               boot_cfg_valid,
    input  logic [NUM_DET-1:0] boot_cfg_word,
    input  logic [NUM_DET-1:0] trip_raw,
    input  logic               reg_wr,
    input  logic [2:0]         reg_addr,
    input  logic [NUM_DET-1:0] reg_wdata,
    output logic [NUM_DET-1:0] reg_rdata,
    output logic               func_rst_req,
    output logic               dest_rst_req,
    output logic               irq,
    output logic               fault_evt,
    output logic               ext_rst_n,
    output logic               hold_phase0
);
    vdr_state_e state_q, state_d;

    logic [NUM_DET-1:0] deb_lvl, trip_rise;
    logic [NUM_DET-1:0] ree_q, rtype_q, ie_q, fee_q, pend_q, lock_q;
    logic               apply, wr_en;
    logic               func_any, dest_any, irq_any, flt_any, hold_any;

    // state register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) state_q <= ST_WAIT_BOOT;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT_BOOT: if (boot_cfg_valid) state_d = ST_APPLY;
            ST_APPLY:     state_d = ST_RUN;
            ST_RUN:       state_d = ST_RUN;
            default:      state_d = ST_WAIT_BOOT;
        endcase
    end

    assign apply = (state_q == ST_WAIT_BOOT) && boot_cfg_valid;
    assign wr_en = (state_q == ST_RUN) && reg_wr;

    for (genvar i = 0; i < NUM_DET; i++) begin : g_deb
        vdr_debounce #(.DEB_CYC(DEB_CYC)) u_deb (
            .clk  (clk),
            .por_n(por_n),
            .raw  (trip_raw[i]),
            .lvl  (deb_lvl[i]),
            .rise (trip_rise[i])
        );
    end

    vdr_regfile #(.NUM_DET(NUM_DET)) u_regs (
        .clk      (clk),
        .por_n    (por_n),
        .wr_en    (wr_en),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .apply    (apply),
        .boot_word(boot_cfg_word),
        .trip_rise(trip_rise),
        .rdata    (reg_rdata),
        .ree_o    (ree_q),
        .rtype_o  (rtype_q),
        .ie_o     (ie_q),
        .fee_o    (fee_q),
        .pend_o   (pend_q),
        .lock_o   (lock_q)
    );

    vdr_route #(.NUM_DET(NUM_DET)) u_route (
        .pend    (pend_q),
        .ree     (ree_q),
        .rtype   (rtype_q),
        .ie      (ie_q),
        .fee     (fee_q),
        .lvl     (deb_lvl),
        .func_any(func_any),
        .dest_any(dest_any),
        .irq_any (irq_any),
        .flt_any (flt_any),
        .hold_any(hold_any)
    );

    // outputs
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            func_rst_req <= 1'b0;
            dest_rst_req <= 1'b0;
            irq          <= 1'b0;
            fault_evt    <= 1'b0;
            ext_rst_n    <= 1'b1;
            hold_phase0  <= 1'b0;
        end else begin
            func_rst_req <= func_any;
            dest_rst_req <= dest_any;
            irq          <= irq_any;
            fault_evt    <= flt_any;
            ext_rst_n    <= ~dest_any;
            hold_phase0  <= hold_any;
        end
    end
endmodule

// File: rtl/vdr_checker.sv
module vdr_checker
    import vdr_pkg::*;
#(
    parameter int NUM_DET = 12
) (
    input logic               clk,
    input logic               por_n,
    input vdr_state_e         state_q,
    input logic [NUM_DET-1:0] trip_rise,
    input logic [NUM_DET-1:0] deb_lvl,
    input logic [NUM_DET-1:0] pend_q,
    input logic [NUM_DET-1:0] ree_q,
    input logic [NUM_DET-1:0] rtype_q,
    input logic [NUM_DET-1:0] ie_q,
    input logic [NUM_DET-1:0] lock_q,
    input logic               irq,
    input logic               ext_rst_n,
    input logic               hold_phase0
);
    assert_trip_sets_pend_R2: assert property (@(posedge clk) disable iff (!por_n)
        (trip_rise != '0) |=> ((pend_q & $past(trip_rise)) == $past(trip_rise)));

    assert_pin_from_dest_R5: assert property (@(posedge clk) disable iff (!por_n)
        !ext_rst_n |-> $past(|(pend_q & ree_q & rtype_q)));

    assert_irq_source_R6: assert property (@(posedge clk) disable iff (!por_n)
        irq |-> $past(|(pend_q & ie_q)));

    assert_lock_keeps_ree_R7: assert property (@(posedge clk) disable iff (!por_n)
        (lock_q & ~ree_q) == '0);

    assert_hold_needs_trip_R9: assert property (@(posedge clk) disable iff (!por_n)
        hold_phase0 |-> $past(|deb_lvl));

    assert_no_early_write_R10: assert property (@(posedge clk) disable iff (!por_n)
        (state_q != ST_RUN) |=> $stable(ie_q));

    assert_lock_frozen_R10: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == ST_RUN) |=> $stable(lock_q));
endmodule

bind vd_reaction_ctrl vdr_checker #(.NUM_DET(NUM_DET)) u_chk (
    .clk        (clk),
    .por_n      (por_n),
    .state_q    (state_q),
    .trip_rise  (trip_rise),
    .deb_lvl    (deb_lvl),
    .pend_q     (pend_q),
    .ree_q      (ree_q),
    .rtype_q    (rtype_q),
    .ie_q       (ie_q),
    .lock_q     (lock_q),
    .irq        (irq),
    .ext_rst_n  (ext_rst_n),
    .hold_phase0(hold_phase0)
);

// File: tb/vd_reaction_ctrl_tb.sv
`timescale 1ns/1ps
module vd_reaction_ctrl_tb;
    localparam int N   = 4;
    localparam int DEB = 3;

    logic         clk = 1'b0;
    logic         por_n = 1'b0;
    logic         boot_cfg_valid = 1'b0;
    logic [N-1:0] boot_cfg_word = '0;
    logic [N-1:0] trip_raw = '0;
    logic         reg_wr = 1'b0;
    logic [2:0]   reg_addr = '0;
    logic [N-1:0] reg_wdata = '0;
    logic [N-1:0] reg_rdata;
    logic         func_rst_req, dest_rst_req, irq, fault_evt, ext_rst_n, hold_phase0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    vd_reaction_ctrl #(.NUM_DET(N), .DEB_CYC(DEB)) u_dut (
        .clk(clk), .por_n(por_n), .boot_cfg_valid(boot_cfg_valid),
        .boot_cfg_word(boot_cfg_word), .trip_raw(trip_raw), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .func_rst_req(func_rst_req), .dest_rst_req(dest_rst_req), .irq(irq),
        .fault_evt(fault_evt), .ext_rst_n(ext_rst_n), .hold_phase0(hold_phase0)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [2:0] a, input int exp);
        reg_addr = a;
        #0.5;
        chk(req, int'(reg_rdata), exp);
    endtask

    task automatic boot(input logic [N-1:0] w);
        @(negedge clk);
        boot_cfg_word = w; boot_cfg_valid = 1'b1;
        @(negedge clk);
        boot_cfg_valid = 1'b0;
        cyc(2);
    endtask

    task automatic pulse(input int det, input int n);
        @(negedge clk);
        trip_raw[det] = 1'b1;
        cyc(n);
        trip_raw[det] = 1'b0;
        cyc(3);
    endtask

    task automatic outs_chk(input string req, input int f, input int d, input int i, input int e);
        chk({req, " func"}, int'(func_rst_req), f);
        chk({req, " dest"}, int'(dest_rst_req), d);
        chk({req, " irq"}, int'(irq), i);
        chk({req, " fault"}, int'(fault_evt), e);
        chk({req, " pin"}, int'(ext_rst_n), d ? 0 : 1);
    endtask

    task automatic t_reset();
        cyc(2);
        por_n = 1'b1;
        cyc(1);
        outs_chk("R8 reset", 0, 0, 0, 0);
        chk("R8 reset hold", int'(hold_phase0), 0);
        rd_chk("R8 reset ree", 3'd0, 0);
        rd_chk("R8 reset lock", 3'd5, 0);
    endtask

    task automatic t_early_write();
        wr(3'd2, 4'hF);
        rd_chk("R10 write before run ignored", 3'd2, 0);
    endtask

    task automatic t_boot_lock();
        boot(4'b0101);
        rd_chk("R7 lock loaded", 3'd5, 5);
        rd_chk("R7 ree forced", 3'd0, 5);
        wr(3'd0, 4'h0);
        rd_chk("R7 locked bits keep 1", 3'd0, 5);
        wr(3'd0, 4'hA);
        rd_chk("R7 unlocked bits writable", 3'd0, 15);
        wr(3'd0, 4'h0);
        rd_chk("R7 unlocked bits clear", 3'd0, 5);
        boot(4'hF);
        rd_chk("R10 boot in run ignored", 3'd5, 5);
        rd_chk("R3 unused address reads 0", 3'd7, 0);
    endtask

    task automatic t_debounce();
        pulse(1, DEB - 1);
        rd_chk("R1 short pulse rejected", 3'd4, 0);
        pulse(1, DEB);
        rd_chk("R2 pending set without enables", 3'd4, 2);
        outs_chk("R2 no reaction without enables", 0, 0, 0, 0);
    endtask

    task automatic t_reactions();
        wr(3'd2, 4'b0010);
        wr(3'd3, 4'b0010);
        cyc(1);
        outs_chk("R6 irq and fault", 0, 0, 1, 1);
        wr(3'd0, 4'b0010);
        cyc(1);
        outs_chk("R4 functional with irq and fault", 1, 0, 1, 1);
        wr(3'd1, 4'b0010);
        cyc(1);
        outs_chk("R5 destructive", 0, 1, 1, 1);
        chk("R9 no hold after trip ends", int'(hold_phase0), 0);
        @(negedge clk);
        trip_raw[1] = 1'b1;
        cyc(DEB + 2);
        chk("R9 hold while trip present", int'(hold_phase0), 1);
        trip_raw[1] = 1'b0;
        cyc(3);
        chk("R9 hold drops with trip", int'(hold_phase0), 0);
        chk("R5 dest stays while pending", int'(dest_rst_req), 1);
        wr(3'd4, 4'b0001);
        rd_chk("R2 write 1 to other bit leaves pending", 3'd4, 2);
        wr(3'd4, 4'b0010);
        cyc(1);
        rd_chk("R2 write 1 clears", 3'd4, 0);
        outs_chk("R2 reactions clear", 0, 0, 0, 0);
    endtask

    task automatic t_locked_det();
        pulse(0, DEB);
        outs_chk("R7 locked enable gives functional reset", 1, 0, 0, 0);
        wr(3'd4, 4'b0001);
        cyc(1);
        outs_chk("R4 cleared", 0, 0, 0, 0);
    endtask

    task automatic t_repor();
        @(negedge clk);
        trip_raw[2] = 1'b1;
        cyc(DEB + 2);
        trip_raw[2] = 1'b0;
        rd_chk("R2 pending before por", 3'd4, 4);
        por_n = 1'b0;
        #1;
        chk("R8 por clears pin", int'(ext_rst_n), 1);
        cyc(2);
        por_n = 1'b1;
        cyc(1);
        rd_chk("R8 por clears pending", 3'd4, 0);
        rd_chk("R8 por clears lock", 3'd5, 0);
        rd_chk("R8 por clears type", 3'd1, 0);
        boot(4'b0000);
        wr(3'd0, 4'b0001);
        rd_chk("R8 reboot bit writable set", 3'd0, 1);
        wr(3'd0, 4'b0000);
        rd_chk("R8 reboot bit writable clear", 3'd0, 0);
    endtask

    initial begin
        t_reset();
        t_early_write();
        t_boot_lock();
        t_debounce();
        t_reactions();
        t_locked_det();
        t_repor();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule